// File: doc/BRIEF.md
# Host-to-Card Memory Window Translator

This block sits between a host memory bus and a removable-card memory bus. It holds a small set of programmable windows. Each window claims an inclusive range of 4 KB host pages, and for every host cycle that lands in an enabled window it produces the matching card address. The card address is formed by adding a per-window 14-bit page offset to the host page, and the sum wraps at 14 bits.

Each window is programmed through six byte-wide configuration registers. These hold a start page, a stop page and a card offset, and each value is split into a low byte and a high byte. Attribute flags sit in the spare top bits of each high byte: data width, zero-wait, wait-state select, attribute-memory select and write protect. The attributes of the winning window travel with the translated address. A separate enable register gates each window.

Host requests are sampled on a clock edge, and the result is presented one cycle later on registered outputs. A write that lands in a write-protected window is reported as a hit but is blocked from the card.

Top module: `memwin_xlate`

## Requirements
- R1: After reset every window register and the enable register hold zero, so no window decodes and `hit` and `cardEnable` are 0.
- R2: Window w's registers sit at configuration address WIN_BASE + w*REG_STRIDE (defaults 0x10 and 8). The offsets within a group are: 0 start low, 1 start high, 2 stop low, 3 stop high, 4 offset low, 5 offset high. Start and stop high bytes carry page bits 11:8 in bits 3:0. The offset high byte carries offset bits 13:8 in bits 5:0. Writes to group offsets 6 and 7, or to addresses past the last group, change nothing.
- R3: A host request hits window w when the window is enabled and start ≤ hostAddr[23:12] ≤ stop. Both bounds are inclusive.
- R4: On a hit, cardAddr = {(hostAddr[23:12] + offset) mod 2^14, hostAddr[11:0]}.
- R5: The enable register is at configuration address 0x06, and bit w enables window w. A window whose bit is clear never hits.
- R6: When several enabled windows match, the lowest-numbered one wins, and `winIdx` reports its number.
- R7: The winning window's attributes are reported. Start high bit 7 is the 16-bit width flag and bit 6 is zero-wait. Stop high bits 7:6 are the wait-state select. Offset high bit 7 is write protect and bit 6 selects attribute memory.
- R8: A write that hits a write-protected window gives `hit`=1, `cardEnable`=0 and `wrBlocked`=1. A read of the same window gives `cardEnable`=1 and `wrBlocked`=0.
- R9: Outputs are registered. A request sampled at one rising edge is reported after that edge. An edge with `hostValid` low yields `hit`=0 and `cardEnable`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 8 | Configuration register address |
| cfgWrData | input | 8 | Configuration write data |
| hostValid | input | 1 | Host memory request present |
| hostWrite | input | 1 | Host request is a write |
| hostAddr | input | 24 | Host byte address |
| hit | output | 1 | Request landed in an enabled window |
| winIdx | output | 2 | Number of the winning window |
| cardAddr | output | 26 | Translated card byte address |
| attrWide16 | output | 1 | 16-bit data width flag |
| attrZeroWait | output | 1 | Zero-wait-state flag |
| attrWaitSel | output | 2 | Wait-state select |
| attrMem | output | 1 | Attribute-memory select |
| attrWriteProt | output | 1 | Write-protect flag |
| cardEnable | output | 1 | Cycle may proceed to the card |
| wrBlocked | output | 1 | Write suppressed by write protect |

## Verification
The bench probes the first and last page of a window and the pages just outside it. A design with an exclusive stop bound or an off-by-one start compare would miss the last page or claim a neighbour. One window's offset is chosen so that the sum overflows 14 bits, which exposes an adder that carries into a wider card page. Overlapping windows are probed with different enable masks, so a reversed priority or a missing enable gate shows up as the wrong `winIdx` and `cardAddr`. Writes to unused group slots and past the last group must leave translation unchanged. A protected window is probed with both a read and a write, so a protection check that ignores the direction of the cycle is caught.

// File: rtl/memwin_pkg.sv
package memwin_pkg;
  localparam int CFG_AW   = 8;
  localparam int GRP_REGS = 6;

  typedef struct packed {
    logic       enaWr;
    logic       grpWr;
    logic [3:0] grpNum;
    logic [2:0] regOfs;
    logic [7:0] data;
  } cfgStrobe_t;

  typedef struct packed {
    logic       wide16;
    logic       zeroWait;
    logic [1:0] waitSel;
    logic       attrMem;
    logic       writeProt;
  } winAttr_t;
endpackage

// File: rtl/memwin_ctrl.sv
module memwin_ctrl
  import memwin_pkg::*;
#(
  parameter int NUM_WIN    = 4,
  parameter int REG_STRIDE = 8,
  parameter int WIN_BASE   = 16,
  parameter int ENA_ADDR   = 6
) (
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [7:0]        cfgWrData,
  output cfgStrobe_t        stb
);
  localparam int STRIDE_LG = $clog2(REG_STRIDE);
  localparam int SPAN      = NUM_WIN * REG_STRIDE;

  logic [CFG_AW-1:0] relAddr;
  logic [CFG_AW-1:0] inOfs;
  logic              inRange;

  always_comb begin
    relAddr = cfgAddr - CFG_AW'(WIN_BASE);
    inOfs   = relAddr & CFG_AW'(REG_STRIDE - 1);
    inRange = (cfgAddr >= CFG_AW'(WIN_BASE)) && ({1'b0, relAddr} < (CFG_AW+1)'(SPAN));
    stb.enaWr  = cfgWrEn && (cfgAddr == CFG_AW'(ENA_ADDR));
    stb.grpWr  = cfgWrEn && inRange && (inOfs < CFG_AW'(GRP_REGS));
    stb.grpNum = 4'(relAddr >> STRIDE_LG);
    stb.regOfs = inOfs[2:0];
    stb.data   = cfgWrData;
  end

  initial begin
    a_r2_layout_fits : assert (REG_STRIDE >= GRP_REGS && NUM_WIN <= 8 && NUM_WIN >= 1);
  end
endmodule

// File: rtl/memwin_match.sv
module memwin_match
  import memwin_pkg::*;
#(
  parameter int PAGE_W = 12,
  parameter int OFS_W  = 14
) (
  input  logic              winOn,
  input  logic [PAGE_W-1:0] startPg,
  input  logic [PAGE_W-1:0] stopPg,
  input  logic [OFS_W-1:0]  ofsPg,
  input  logic [PAGE_W-1:0] hostPage,
  output logic              isMatch,
  output logic [OFS_W-1:0]  cardPage
);
  always_comb begin
    isMatch  = winOn && (hostPage >= startPg) && (hostPage <= stopPg);
    cardPage = OFS_W'(hostPage) + ofsPg;
  end
endmodule

// File: rtl/memwin_dp.sv
module memwin_dp
  import memwin_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int ADDR_W  = 24,
  parameter int PAGE_W  = 12,
  parameter int OFS_W   = 14
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  cfgStrobe_t                stb,
  input  logic                      hostValid,
  input  logic                      hostWrite,
  input  logic [ADDR_W-1:0]         hostAddr,
  output logic                      hitQ,
  output logic [((NUM_WIN>1)?$clog2(NUM_WIN):1)-1:0] winIdxQ,
  output logic [OFS_W+ADDR_W-PAGE_W-1:0] cardAddrQ,
  output winAttr_t                  attrQ,
  output logic                      cardEnQ,
  output logic                      wrBlkQ
);
  localparam int WIN_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
  localparam int LOW_W = ADDR_W - PAGE_W;
  localparam int HI_W  = PAGE_W - 8;
  localparam int OHI_W = OFS_W - 8;

  logic [NUM_WIN-1:0] winEna;
  logic [NUM_WIN-1:0] matchVec;
  logic [OFS_W-1:0]   cardPgArr [NUM_WIN];
  winAttr_t           attrArr   [NUM_WIN];
  logic [PAGE_W-1:0]  hostPage;

  assign hostPage = hostAddr[ADDR_W-1 -: PAGE_W];

  always_ff @(posedge clk) begin
    if (!rstN)          winEna <= '0;
    else if (stb.enaWr) winEna <= stb.data[NUM_WIN-1:0];
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : gen_win
    logic [PAGE_W-1:0] startPg, stopPg;
    logic [OFS_W-1:0]  ofsPg;
    winAttr_t          attr;
    logic              selMe;

    assign selMe = stb.grpWr && (stb.grpNum == 4'(w));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        startPg <= '0;
        stopPg  <= '0;
        ofsPg   <= '0;
        attr    <= '0;
      end else if (selMe) begin
        case (stb.regOfs)
          3'd0: startPg[7:0] <= stb.data;
          3'd1: begin
            startPg[PAGE_W-1:8] <= stb.data[HI_W-1:0];
            attr.wide16         <= stb.data[7];
            attr.zeroWait       <= stb.data[6];
          end
          3'd2: stopPg[7:0] <= stb.data;
          3'd3: begin
            stopPg[PAGE_W-1:8] <= stb.data[HI_W-1:0];
            attr.waitSel       <= stb.data[7:6];
          end
          3'd4: ofsPg[7:0] <= stb.data;
          3'd5: begin
            ofsPg[OFS_W-1:8] <= stb.data[OHI_W-1:0];
            attr.writeProt   <= stb.data[7];
            attr.attrMem     <= stb.data[6];
          end
          default: ;
        endcase
      end
    end

    memwin_match #(.PAGE_W(PAGE_W), .OFS_W(OFS_W)) u_match (
      .winOn   (winEna[w]),
      .startPg (startPg),
      .stopPg  (stopPg),
      .ofsPg   (ofsPg),
      .hostPage(hostPage),
      .isMatch (matchVec[w]),
      .cardPage(cardPgArr[w])
    );
    assign attrArr[w] = attr;
  end

  logic             anyHit;
  logic [WIN_W-1:0] selIdx;

  always_comb begin
    anyHit = 1'b0;
    selIdx = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        anyHit = 1'b1;
        selIdx = WIN_W'(i);
      end
    end
    anyHit = anyHit && hostValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitQ      <= 1'b0;
      winIdxQ   <= '0;
      cardAddrQ <= '0;
      attrQ     <= '0;
      cardEnQ   <= 1'b0;
      wrBlkQ    <= 1'b0;
    end else begin
      hitQ      <= anyHit;
      winIdxQ   <= selIdx;
      cardAddrQ <= {cardPgArr[selIdx], hostAddr[LOW_W-1:0]};
      attrQ     <= anyHit ? attrArr[selIdx] : '0;
      cardEnQ   <= anyHit && !(hostWrite && attrArr[selIdx].writeProt);
      wrBlkQ    <= anyHit && hostWrite && attrArr[selIdx].writeProt;
    end
  end

  a_r5_enable_gate : assert property (@(posedge clk) disable iff (!rstN)
    hitQ |-> (($past(winEna) & ((NUM_WIN)'(1) << winIdxQ)) != '0));

  a_r6_lowest_wins : assert property (@(posedge clk) disable iff (!rstN)
    hitQ |-> (($past(matchVec) & (((NUM_WIN)'(1) << winIdxQ) - (NUM_WIN)'(1))) == '0));

  a_r8_block_excl : assert property (@(posedge clk) disable iff (!rstN)
    wrBlkQ |-> (hitQ && !cardEnQ));

  a_r9_idle_no_hit : assert property (@(posedge clk) disable iff (!rstN)
    !$past(hostValid) |-> (!hitQ && !cardEnQ));
endmodule

// File: rtl/memwin_xlate.sv
module memwin_xlate
  import memwin_pkg::*;
#(
  parameter int NUM_WIN    = 4,
  parameter int ADDR_W     = 24,
  parameter int PAGE_W     = 12,
  parameter int OFS_W      = 14,
  parameter int REG_STRIDE = 8,
  parameter int WIN_BASE   = 16,
  parameter int ENA_ADDR   = 6,
  localparam int WIN_W     = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int CARD_W    = OFS_W + ADDR_W - PAGE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [7:0]        cfgWrData,
  input  logic              hostValid,
  input  logic              hostWrite,
  input  logic [ADDR_W-1:0] hostAddr,
  output logic              hit,
  output logic [WIN_W-1:0]  winIdx,
  output logic [CARD_W-1:0] cardAddr,
  output logic              attrWide16,
  output logic              attrZeroWait,
  output logic [1:0]        attrWaitSel,
  output logic              attrMem,
  output logic              attrWriteProt,
  output logic              cardEnable,
  output logic              wrBlocked
);
  cfgStrobe_t stb;
  winAttr_t   attrOut;

  memwin_ctrl #(
    .NUM_WIN(NUM_WIN), .REG_STRIDE(REG_STRIDE),
    .WIN_BASE(WIN_BASE), .ENA_ADDR(ENA_ADDR)
  ) u_ctrl (
    .cfgWrEn  (cfgWrEn),
    .cfgAddr  (cfgAddr),
    .cfgWrData(cfgWrData),
    .stb      (stb)
  );

  memwin_dp #(
    .NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .OFS_W(OFS_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .hostValid(hostValid),
    .hostWrite(hostWrite),
    .hostAddr (hostAddr),
    .hitQ     (hit),
    .winIdxQ  (winIdx),
    .cardAddrQ(cardAddr),
    .attrQ    (attrOut),
    .cardEnQ  (cardEnable),
    .wrBlkQ   (wrBlocked)
  );

  assign attrWide16    = attrOut.wide16;
  assign attrZeroWait  = attrOut.zeroWait;
  assign attrWaitSel   = attrOut.waitSel;
  assign attrMem       = attrOut.attrMem;
  assign attrWriteProt = attrOut.writeProt;
endmodule

// File: tb/memwin_xlate_test.sv
module memwin_xlate_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [7:0]  cfgAddr = '0;
  logic [7:0]  cfgWrData = '0;
  logic        hostValid = 1'b0;
  logic        hostWrite = 1'b0;
  logic [23:0] hostAddr = '0;
  logic        hit;
  logic [1:0]  winIdx;
  logic [25:0] cardAddr;
  logic        attrWide16, attrZeroWait, attrMem, attrWriteProt;
  logic [1:0]  attrWaitSel;
  logic        cardEnable, wrBlocked;

  int checks = 0;
  int errs   = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  memwin_xlate uut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .hostValid(hostValid), .hostWrite(hostWrite),
    .hostAddr(hostAddr), .hit(hit), .winIdx(winIdx), .cardAddr(cardAddr),
    .attrWide16(attrWide16), .attrZeroWait(attrZeroWait),
    .attrWaitSel(attrWaitSel), .attrMem(attrMem),
    .attrWriteProt(attrWriteProt), .cardEnable(cardEnable),
    .wrBlocked(wrBlocked)
  );

  task automatic chkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfgWr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic progWin(input int w, input logic [11:0] st, input logic [11:0] sp,
                         input logic [13:0] of, input logic [7:0] stF,
                         input logic [7:0] spF, input logic [7:0] ofF);
    logic [7:0] b;
    b = 8'(16 + w * 8);
    cfgWr(b + 8'd0, st[7:0]);
    cfgWr(b + 8'd1, stF | {4'h0, st[11:8]});
    cfgWr(b + 8'd2, sp[7:0]);
    cfgWr(b + 8'd3, spF | {4'h0, sp[11:8]});
    cfgWr(b + 8'd4, of[7:0]);
    cfgWr(b + 8'd5, ofF | {2'b00, of[13:8]});
  endtask

  task automatic probe(input logic wr, input logic [23:0] a);
    @(negedge clk);
    hostValid = 1'b1; hostWrite = wr; hostAddr = a;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [25:0] expCard(input logic [23:0] a, input logic [13:0] of);
    logic [13:0] pg;
    pg = 14'(a[23:12]) + of;
    return {pg, a[11:0]};
  endfunction

  task automatic t_reset;
    chkEq("R1 hit after reset", 32'(hit), 0);
    chkEq("R1 cardEnable after reset", 32'(cardEnable), 0);
    probe(1'b0, 24'h000123);
    chkEq("R1 no window decodes after reset", 32'(hit), 0);
  endtask

  task automatic t_basic;
    progWin(0, 12'h100, 12'h10F, 14'h1F00, 8'h00, 8'h00, 8'h00);
    probe(1'b0, 24'h100ABC);
    chkEq("R5 disabled window no hit", 32'(hit), 0);
    cfgWr(8'h06, 8'h01);
    probe(1'b0, 24'h100ABC);
    chkEq("R3 start page hit", 32'(hit), 1);
    chkEq("R4 card addr start", 32'(cardAddr), 32'(expCard(24'h100ABC, 14'h1F00)));
    probe(1'b0, 24'h10FFFF);
    chkEq("R3 inclusive stop hit", 32'(hit), 1);
    chkEq("R4 card addr stop", 32'(cardAddr), 32'h200FFFF);
    probe(1'b0, 24'h110000);
    chkEq("R3 page past stop misses", 32'(hit), 0);
    probe(1'b0, 24'h0FFFFF);
    chkEq("R3 page before start misses", 32'(hit), 0);
  endtask

  task automatic t_wrap;
    progWin(1, 12'hF00, 12'hFFF, 14'h3200, 8'h00, 8'h00, 8'h00);
    cfgWr(8'h06, 8'h03);
    probe(1'b0, 24'hF00123);
    chkEq("R4 wrap hit", 32'(hit), 1);
    chkEq("R6 winIdx window1", 32'(winIdx), 1);
    chkEq("R4 wrapped card addr", 32'(cardAddr), 32'h0100123);
  endtask

  task automatic t_prio;
    progWin(2, 12'hF80, 12'hFFF, 14'h0000, 8'h00, 8'h00, 8'h00);
    cfgWr(8'h06, 8'h07);
    probe(1'b0, 24'hF90000);
    chkEq("R6 lowest window wins", 32'(winIdx), 1);
    chkEq("R6 card addr from window1", 32'(cardAddr), 32'(expCard(24'hF90000, 14'h3200)));
    cfgWr(8'h06, 8'h05);
    probe(1'b0, 24'hF90000);
    chkEq("R5 disabled window1 yields window2", 32'(winIdx), 2);
    chkEq("R5 card addr from window2", 32'(cardAddr), 32'h0F90000);
    probe(1'b0, 24'hF10000);
    chkEq("R5 page only in disabled window misses", 32'(hit), 0);
  endtask

  task automatic t_attr;
    progWin(3, 12'h400, 12'h400, 14'h0000, 8'h80, 8'h40, 8'h40);
    cfgWr(8'h06, 8'h0D);
    probe(1'b0, 24'h400010);
    chkEq("R7 single page window hit", 32'(hit), 1);
    chkEq("R7 wide16", 32'(attrWide16), 1);
    chkEq("R7 zeroWait", 32'(attrZeroWait), 0);
    chkEq("R7 waitSel", 32'(attrWaitSel), 1);
    chkEq("R7 attrMem", 32'(attrMem), 1);
    chkEq("R7 writeProt clear", 32'(attrWriteProt), 0);
    probe(1'b1, 24'h400010);
    chkEq("R8 unprotected write enabled", 32'(cardEnable), 1);
  endtask

  task automatic t_wp;
    cfgWr(8'h10 + 8'd24 + 8'd5, 8'h80);
    probe(1'b0, 24'h400020);
    chkEq("R8 protected read enabled", 32'(cardEnable), 1);
    chkEq("R8 protected read not blocked", 32'(wrBlocked), 0);
    probe(1'b1, 24'h400020);
    chkEq("R8 protected write hit", 32'(hit), 1);
    chkEq("R8 protected write suppressed", 32'(cardEnable), 0);
    chkEq("R8 protected write flagged", 32'(wrBlocked), 1);
    chkEq("R7 writeProt reported", 32'(attrWriteProt), 1);
  endtask

  task automatic t_ignore;
    cfgWr(8'h16, 8'hFF);
    cfgWr(8'h17, 8'hFF);
    cfgWr(8'h30, 8'hFF);
    cfgWr(8'h31, 8'hFF);
    probe(1'b0, 24'h100ABC);
    chkEq("R2 unused slots leave hit", 32'(hit), 1);
    chkEq("R2 unused slots leave card addr", 32'(cardAddr), 32'h2000ABC);
    probe(1'b0, 24'h110000);
    chkEq("R2 unused slots leave stop bound", 32'(hit), 0);
  endtask

  task automatic t_idle;
    probe(1'b0, 24'h100000);
    chkEq("R9 hit after request edge", 32'(hit), 1);
    @(negedge clk);
    hostValid = 1'b0;
    @(posedge clk);
    #1;
    chkEq("R9 idle edge clears hit", 32'(hit), 0);
    chkEq("R9 idle edge clears cardEnable", 32'(cardEnable), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_basic();
    t_wrap();
    t_prio();
    t_attr();
    t_wp();
    t_ignore();
    t_idle();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      checks++;
      errs++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule